// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a simple in-order core and decides, once per clock, where the next instruction is fetched from. Each cycle it sees the instruction currently being executed together with the two register operands already read for it (the values named by the two source fields), and from these it selects one of several successor addresses: the next sequential word, a PC-relative branch target, a pseudo-direct jump target, or an address held in a register.

For the call instruction the block also raises a one-cycle register write request aimed at the fixed return-address register, carrying the address of the instruction after the call. The request is combinational with the current instruction and program counter, so the register file can commit it at the same clock edge that moves the PC. A synchronous active-high reset loads a configurable start address, and a stall input freezes the PC and silences the write request.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` is loaded with the parameter `START_ADDR` (default 0x0040_0000), and `link_we` stays low for any instruction while `rst` is high.
- R2: An instruction whose opcode (bits 31:26) is none of 0, 2, 3, 4, 5, or an opcode-0 instruction whose function field (bits 5:0) is not 8, advances `pc` by 4 at the next edge, wrapping modulo 2^32.
- R3: Opcode 4 (branch when equal): if `rs_val` equals `rt_val`, the next `pc` is `pc + 4` plus the sign-extended bits 15:0 shifted left by two; otherwise it is `pc + 4`.
- R4: Opcode 5 (branch when different): if `rs_val` differs from `rt_val`, the next `pc` is `pc + 4` plus the sign-extended bits 15:0 shifted left by two; otherwise it is `pc + 4`.
- R5: Opcode 2 (jump): the next `pc` is bits 31:28 of the current `pc`, followed by instruction bits 25:0, followed by two zero bits.
- R6: Opcode 3 (call): the next `pc` is formed as in R5, and in the same cycle `link_we` is high, `link_idx` is 31 and `link_data` is the current `pc + 4`.
- R7: Opcode 0 with function field 8 (register jump): the next `pc` is `rs_val`.
- R8: While `stall` is high (and `rst` low), `pc` keeps its value at the edge and `link_we` is low, whatever the instruction.
- R9: `link_we` is high only for opcode 3, so it is high for exactly one cycle per unstalled call instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the PC and suppress the link write |
| instr | input | 32 | Instruction at the current PC |
| rs_val | input | 32 | Value read for the first source register |
| rt_val | input | 32 | Value read for the second source register |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Destination register index of the link write (always 31) |
| link_data | output | 32 | Return address, current PC plus 4 |

## Verification
The two functions that share a cycle are the control transfer chosen by the instruction and the stall or reset that overrides it: a call or taken branch is presented in the same cycle as `stall` or `rst`, and the bench expects the PC to hold (or load the start address) with no link write. A second overlap is the call's link request and its PC jump, judged together in one cycle against `pc + 4` and the pseudo-direct target. A behavioural reference model tracks the PC from the opcode and operands and is compared after every edge, including negative branch offsets, upper-bit retention on jumps and wrap past the top of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN        = 32;
    localparam int OPC_W       = 6;
    localparam int FN_W        = 6;
    localparam int IMM_W       = 16;
    localparam int JIDX_W      = 26;
    localparam int REG_IDX_W   = 5;
    localparam int REGION_W    = 4;
    localparam int WORD_SHIFT  = 2;
    localparam int INSTR_BYTES = 4;

    localparam int OPC_LSB = XLEN - OPC_W;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_CALL  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BREQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BRNE  = 6'd5;
    localparam logic [FN_W-1:0]  FN_REGJMP = 6'd8;

    localparam logic [REG_IDX_W-1:0] RET_REG = 5'd31;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BREQ,
        FLOW_BRNE,
        FLOW_JUMP,
        FLOW_CALL,
        FLOW_REGJMP
    } flow_e;

    typedef struct packed {
        flow_e              kind;
        logic [IMM_W-1:0]   disp;
        logic [JIDX_W-1:0]  jidx;
    } decoded_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] direct;
        logic [XLEN-1:0] indirect;
    } cand_t;

    function automatic logic [XLEN-1:0] scaled_disp(input logic [IMM_W-1:0] d);
        logic [XLEN-1:0] ext;
        ext = {{(XLEN-IMM_W){d[IMM_W-1]}}, d};
        return ext << WORD_SHIFT;
    endfunction

    function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] cur,
                                                      input logic [JIDX_W-1:0] idx);
        return {cur[XLEN-1 -: REGION_W], idx, {WORD_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output decoded_t        dec
);

    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;

    assign opc = instr[XLEN-1 -: OPC_W];
    assign fn  = instr[FN_W-1:0];

    always_comb begin
        dec.disp = instr[IMM_W-1:0];
        dec.jidx = instr[JIDX_W-1:0];
        dec.kind = FLOW_SEQ;
        unique case (opc)
            OPC_REG:  dec.kind = (fn == FN_REGJMP) ? FLOW_REGJMP : FLOW_SEQ;
            OPC_JUMP: dec.kind = FLOW_JUMP;
            OPC_CALL: dec.kind = FLOW_CALL;
            OPC_BREQ: dec.kind = FLOW_BREQ;
            OPC_BRNE: dec.kind = FLOW_BRNE;
            default:  dec.kind = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  decoded_t        dec,
    input  logic [XLEN-1:0] rs_val,
    output cand_t           cand
);

    logic [XLEN-1:0] seq_addr;

    assign seq_addr = pc + XLEN'(INSTR_BYTES);

    always_comb begin
        cand.seq      = seq_addr;
        cand.branch   = seq_addr + scaled_disp(dec.disp);
        cand.direct   = region_target(pc, dec.jidx);
        cand.indirect = rs_val;
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  flow_e           kind,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  cand_t           cand,
    output logic [XLEN-1:0] next_pc,
    output logic            is_call
);

    logic same;

    assign same = (rs_val == rt_val);

    always_comb begin
        next_pc = cand.seq;
        is_call = 1'b0;
        unique case (kind)
            FLOW_BREQ:   next_pc = same  ? cand.branch : cand.seq;
            FLOW_BRNE:   next_pc = !same ? cand.branch : cand.seq;
            FLOW_JUMP:   next_pc = cand.direct;
            FLOW_CALL: begin
                next_pc = cand.direct;
                is_call = 1'b1;
            end
            FLOW_REGJMP: next_pc = cand.indirect;
            default:     next_pc = cand.seq;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] START_ADDR = 32'h0040_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  logic [XLEN-1:0]      instr,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    output logic [XLEN-1:0]      pc,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_data
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] next_pc;
    logic            is_call;
    decoded_t        dec;
    cand_t           cand;

    npc_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    npc_targets u_targets (
        .pc     (pc_q),
        .dec    (dec),
        .rs_val (rs_val),
        .cand   (cand)
    );

    npc_select u_select (
        .kind    (dec.kind),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .cand    (cand),
        .next_pc (next_pc),
        .is_call (is_call)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= START_ADDR;
        end else if (!stall) begin
            pc_q <= next_pc;
        end
    end

    assign pc        = pc_q;
    assign link_we   = is_call && !stall && !rst;
    assign link_idx  = RET_REG;
    assign link_data = cand.seq;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] START_ADDR = 32'h0040_0000
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 stall,
    input logic [XLEN-1:0]      instr,
    input logic [XLEN-1:0]      rs_val,
    input logic [XLEN-1:0]      pc,
    input logic                 link_we,
    input logic [REG_IDX_W-1:0] link_idx,
    input logic [XLEN-1:0]      link_data
);

    logic [OPC_W-1:0] opc;
    logic             plain;

    assign opc   = instr[XLEN-1 -: OPC_W];
    assign plain = !(opc inside {OPC_JUMP, OPC_CALL, OPC_BREQ, OPC_BRNE})
                   && !(opc == OPC_REG && instr[FN_W-1:0] == FN_REGJMP);

    // R1
    reset_start_chk: assert property (@(posedge clk) rst |=> pc == START_ADDR);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |-> !link_we);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && plain) |=> pc == $past(pc) + 32'd4);

    // R7
    reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && opc == OPC_REG && instr[FN_W-1:0] == FN_REGJMP) |=> pc == $past(rs_val));

    // R6
    call_target_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |=> pc[XLEN-1 -: REGION_W] == $past(pc[XLEN-1 -: REGION_W])
                    && pc[JIDX_W+1:2] == $past(instr[JIDX_W-1:0]) && pc[1:0] == 2'b00);

    // R6
    call_link_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_idx == 5'd31 && link_data == pc + 32'd4);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc));

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> !link_we);

    // R9
    link_source_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> opc == OPC_CALL);

endmodule

bind npc_unit npc_unit_chk #(.START_ADDR(START_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .instr     (instr),
    .rs_val    (rs_val),
    .pc        (pc),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .link_data (link_data)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;

    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] mpc;

    always #2.5 clk = ~clk;

    npc_unit #(.START_ADDR(START)) u_npc_unit (
        .clk(clk), .rst(rst), .stall(stall), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
    );

    function automatic logic [31:0] itype(input int op, input logic [15:0] imm);
        return {6'(op), 5'd1, 5'd2, imm};
    endfunction

    function automatic logic [31:0] jtype(input int op, input logic [25:0] idx);
        return {6'(op), idx};
    endfunction

    function automatic logic [31:0] rtype(input int fn);
        return {6'd0, 5'd3, 5'd4, 5'd5, 5'd0, 6'(fn)};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [31:0] ins,
                                               input logic [31:0] a, input logic [31:0] b);
        int op;
        int off;
        op  = int'(ins[31:26]);
        off = int'($signed(ins[15:0])) * 4;
        case (op)
            0: return (ins[5:0] == 6'd8) ? a : cur + 32'd4;
            2, 3: return {cur[31:28], ins[25:0], 2'b00};
            4: return (a == b) ? cur + 32'd4 + 32'(off) : cur + 32'd4;
            5: return (a != b) ? cur + 32'd4 + 32'(off) : cur + 32'd4;
            default: return cur + 32'd4;
        endcase
    endfunction

    task automatic step(input string tag, input logic r, input logic s,
                        input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic        exp_we;
        logic [31:0] nxt;
        @(negedge clk);
        rst = r; stall = s; instr = ins; rs_val = a; rt_val = b;
        #1;
        exp_we = !r && !s && (ins[31:26] == 6'd3);
        check(tag, "link_we", 32'(link_we), 32'(exp_we));
        if (exp_we) begin
            check(tag, "link_idx", 32'(link_idx), 32'd31);
            check(tag, "link_data", link_data, mpc + 32'd4);
        end
        if (r) nxt = START;
        else if (s) nxt = mpc;
        else nxt = model_next(mpc, ins, a, b);
        @(posedge clk);
        mpc = nxt;
        #1;
        check(tag, "pc", pc, mpc);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        instr = jtype(3, 26'h11);
        repeat (2) @(posedge clk);
        mpc = START;
        @(negedge clk);
        check("R1", "link_we in reset", 32'(link_we), 32'd0);
        check("R1", "pc after reset", pc, START);

        step("R2", 0, 0, itype(6'h23, 16'h0010), 32'h1, 32'h2);
        step("R2", 0, 0, rtype(6'h20), 32'h1, 32'h2);
        step("R3", 0, 0, itype(4, 16'h0003), 32'h5, 32'h5);
        step("R3", 0, 0, itype(4, 16'h0003), 32'h5, 32'h6);
        step("R3", 0, 0, itype(4, 16'hFFF0), 32'h9, 32'h9);
        step("R4", 0, 0, itype(5, 16'h0002), 32'h1, 32'h7);
        step("R4", 0, 0, itype(5, 16'h0002), 32'h7, 32'h7);
        step("R4", 0, 0, itype(5, 16'h8000), 32'h0, 32'h1);
        step("R5", 0, 0, jtype(2, 26'h0123456), 32'h0, 32'h0);
        step("R7", 0, 0, rtype(8), 32'hA000_1000, 32'h0);
        step("R5", 0, 0, jtype(2, 26'h0000040), 32'h0, 32'h0);
        step("R6", 0, 0, jtype(3, 26'h0000100), 32'h0, 32'h0);
        step("R6", 0, 0, jtype(3, 26'h0000200), 32'h0, 32'h0);
        step("R8", 0, 1, jtype(3, 26'h3FFFFFF), 32'h0, 32'h0);
        step("R8", 0, 1, itype(4, 16'h0040), 32'h3, 32'h3);
        step("R7", 0, 0, rtype(8), 32'hFFFF_FFFC, 32'h0);
        step("R2", 0, 0, itype(6'h08, 16'h0001), 32'h0, 32'h0);
        step("R7", 0, 0, rtype(9), 32'h1234_5678, 32'h0);
        step("R9", 0, 0, rtype(3), 32'h0, 32'h0);
        step("R9", 0, 0, itype(6'h2B, 16'h0004), 32'h0, 32'h0);
        step("R1", 1, 0, jtype(3, 26'h0000055), 32'h0, 32'h0);
        step("R6", 0, 0, jtype(3, 26'h0000055), 32'h0, 32'h0);
        step("R3", 0, 0, itype(4, 16'h7FFF), 32'hC, 32'hC);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule